// File: doc/BRIEF.md
# Auxiliary PWM Timer with Shadowed Period and Compare

This block turns a free-running up-counter into a single-output pulse-width modulator. Software programs a period count and a compare count through a small register bus. The counter climbs from zero to the period value and then restarts. The compare count decides how many clocks of each period sit at the active level. A polarity bit selects whether the compare count measures high time or low time.

Each of the two counts exists twice: an active copy that drives the waveform and a shadow copy. Writing an active copy takes effect on the next clock. While the output runs, software writes the shadow copies instead. Only shadow copies written since the last transfer move into the active copies, and they move on the clock where the counter wraps. The period in progress therefore always finishes with the values it started with. Two enable bits in the control word gate the counter. When either bit is clear, the counter is held at zero and the output is held low.

Top module: `aux_pwm_timer`

## Requirements
- R1: After reset, every register reads as zero and `pwm_o` is low.
- R2: The registers are a word at a time at byte offsets 0x08 (active period), 0x0C (active compare), 0x10 (shadow period), 0x14 (shadow compare), plus the 16-bit control word in bits 31:16 of the word at 0x28. A write updates only the bytes whose `bus_be` bit is set, and a read returns the current contents. Any other address, including a misaligned one, is ignored on write and reads as zero.
- R3: The counter runs only when control bit 9 (wave enable) and control bit 4 (count enable) are both 1. Otherwise the counter is held at 0 and `pwm_o` is low.
- R4: While running, the counter goes from 0 up to the active period P and returns to 0 on the next clock, so one period lasts P+1 clocks.
- R5: With control bit 10 at 0, `pwm_o` is high exactly while the counter is below the active compare value C.
- R6: With control bit 10 at 1, the level is swapped: `pwm_o` is low while the counter is below C and high otherwise.
- R7: C = 0 with bit 10 at 0 gives a constant low output. C > P gives a constant high output. C = P gives P high clocks and one low clock.
- R8: A shadow write does not change the active values before the current period ends. It is copied into the matching active register on the wrap clock.
- R9: A shadow register is copied only if it was written since its last copy. An active value written directly after a transfer is therefore not overwritten by a stale shadow value at later wraps.
- R10: A shadow write on a wrap clock is kept pending and moves at the following wrap. A direct active write on a wrap clock takes priority over a transfer on the same clock.
- R11: Clearing the enable bits in the middle of a period drives `pwm_o` low from the next clock. After the bits are set again, the waveform starts over at counter value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the current bus address |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_o | output | 1 | Modulated output |

## Verification
The delicate overlap is a software write landing on the same clock as the counter wrap. The register logic must then decide between the transfer and the new write, both for a shadow write (it must stay pending for one more period) and for a direct active write (it must win). The bench tracks the counter phase in its own model and steps idle clocks until the wrap clock comes up. It then issues the write on exactly that clock and compares the following periods' waveform and a register read-back against the expected outcome. Shadow updates in the middle of a period are judged the same way: the output is sampled every clock to confirm that the old period completes before the new one begins.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 6;
  localparam int CTRL_W = 16;

  localparam logic [ADDR_W-1:0] OFS_APER = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_ACMP = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_SPER = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_SCMP = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h28;

  localparam int CB_COUNT = 4;
  localparam int CB_WAVE  = 9;
  localparam int CB_POL   = 10;

  function automatic logic [BUS_W-1:0] merge_bytes(
    input logic [BUS_W-1:0]   old_v,
    input logic [BUS_W-1:0]   new_v,
    input logic [BUS_W/8-1:0] lanes
  );
    logic [BUS_W-1:0] res;
    for (int i = 0; i < BUS_W/8; i++) begin
      res[8*i +: 8] = lanes[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/aux_pwm_regs.sv
module aux_pwm_regs
  import aux_pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BUS_W-1:0]      wdata,
  input  logic [BUS_W/8-1:0]    be,
  input  logic                  wrap,
  output logic [CNT_W-1:0]      act_per,
  output logic [CNT_W-1:0]      act_cmp,
  output logic [CTRL_W-1:0]     ctrl,
  output logic [BUS_W-1:0]      rdata
);
  localparam int LANES = 2;

  logic [LANES*CNT_W-1:0] act_bus;
  logic [LANES*CNT_W-1:0] sh_bus;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [ADDR_W-1:0] A_OFS = (g == 0) ? OFS_APER : OFS_ACMP;
    localparam logic [ADDR_W-1:0] S_OFS = (g == 0) ? OFS_SPER : OFS_SCMP;

    logic             hit_a, hit_s, xfer, lane_en;
    logic [CNT_W-1:0] act_q, act_d, sh_q, sh_d;
    logic             pend_q, pend_d;

    assign hit_a   = wr_en && (addr == A_OFS);
    assign hit_s   = wr_en && (addr == S_OFS);
    assign xfer    = wrap && pend_q;
    assign lane_en = hit_a || hit_s || xfer;

    always_comb begin
      act_d  = act_q;
      sh_d   = sh_q;
      pend_d = pend_q;
      if (xfer) begin
        act_d  = sh_q;
        pend_d = 1'b0;
      end
      if (hit_a) begin
        act_d = CNT_W'(merge_bytes(BUS_W'(act_d), wdata, be));
      end
      if (hit_s) begin
        sh_d   = CNT_W'(merge_bytes(BUS_W'(sh_q), wdata, be));
        pend_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q  <= '0;
        sh_q   <= '0;
        pend_q <= 1'b0;
      end else if (lane_en) begin
        act_q  <= act_d;
        sh_q   <= sh_d;
        pend_q <= pend_d;
      end
    end

    assign act_bus[g*CNT_W +: CNT_W] = act_q;
    assign sh_bus[g*CNT_W +: CNT_W]  = sh_q;
  end

  logic                 hit_c;
  logic [CTRL_W-1:0]    ctrl_q, ctrl_d;
  logic [BUS_W-1:0]     ctrl_merged;

  assign hit_c       = wr_en && (addr == OFS_CTRL);
  assign ctrl_merged = merge_bytes({ctrl_q, {(BUS_W-CTRL_W){1'b0}}}, wdata, be);
  assign ctrl_d      = ctrl_merged[BUS_W-1 -: CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (hit_c) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign act_per = act_bus[0 +: CNT_W];
  assign act_cmp = act_bus[CNT_W +: CNT_W];
  assign ctrl    = ctrl_q;

  always_comb begin
    unique case (addr)
      OFS_APER: rdata = BUS_W'(act_bus[0 +: CNT_W]);
      OFS_ACMP: rdata = BUS_W'(act_bus[CNT_W +: CNT_W]);
      OFS_SPER: rdata = BUS_W'(sh_bus[0 +: CNT_W]);
      OFS_SCMP: rdata = BUS_W'(sh_bus[CNT_W +: CNT_W]);
      OFS_CTRL: rdata = {ctrl_q, {(BUS_W-CTRL_W){1'b0}}};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/aux_pwm_counter.sv
module aux_pwm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign wrap   = run && (cnt_q >= period);
  assign cnt_en = run || (cnt_q != '0);

  always_comb begin
    if (!run || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/aux_pwm_wave.sv
module aux_pwm_wave #(
  parameter int CNT_W = 32
) (
  input  logic             run,
  input  logic             invert,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             level
);
  logic below;

  assign below = (cnt < cmp);
  assign level = run && (below ^ invert);
endmodule

// File: rtl/aux_pwm_timer.sv
module aux_pwm_timer
  import aux_pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_be,
  output logic [31:0] bus_rdata,
  output logic        pwm_o
);
  logic [1:0]        rs_q;
  logic              rst_s;
  logic [CNT_W-1:0]  act_per, act_cmp, cnt;
  logic [CTRL_W-1:0] ctrl;
  logic              run, wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_s = rs_q[1];

  assign run = ctrl[CB_WAVE] && ctrl[CB_COUNT];

  aux_pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .be      (bus_be),
    .wrap    (wrap),
    .act_per (act_per),
    .act_cmp (act_cmp),
    .ctrl    (ctrl),
    .rdata   (bus_rdata)
  );

  aux_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_s),
    .run    (run),
    .period (act_per),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  aux_pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .run    (run),
    .invert (ctrl[CB_POL]),
    .cnt    (cnt),
    .cmp    (act_cmp),
    .level  (pwm_o)
  );
endmodule

// File: rtl/aux_pwm_chk.sv
module aux_pwm_chk
  import aux_pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [5:0]        addr,
  input logic [CTRL_W-1:0] ctrl,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  per,
  input logic [CNT_W-1:0]  cmp,
  input logic              wrap,
  input logic              pwm
);
  logic on, inv;
  assign on  = ctrl[CB_WAVE] && ctrl[CB_COUNT];
  assign inv = ctrl[CB_POL];

  // R3
  stop_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> cnt == '0);

  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> !pwm);

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on && (cnt >= per) |=> cnt == '0);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on && (cnt < per) |=> cnt == $past(cnt) + 1'b1);

  // R5
  normal_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on && !inv && (cnt < cmp) |-> pwm);

  // R6
  invert_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on && inv && (cnt < cmp) |-> !pwm);

  // R8
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap && !(wr && addr == OFS_APER) |=> $stable(per));
endmodule

bind aux_pwm_timer aux_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk  (clk),
  .rst_n(rst_s),
  .wr   (bus_wr),
  .addr (bus_addr),
  .ctrl (ctrl),
  .cnt  (cnt),
  .per  (act_per),
  .cmp  (act_cmp),
  .wrap (wrap),
  .pwm  (pwm_o)
);

// File: tb/tb_aux_pwm_timer.sv
module tb_aux_pwm_timer;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata;
  logic        pwm_o;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  logic last_pwm;

  // reference state, derived from the requirements
  logic [31:0] m_act [2];
  logic [31:0] m_sh  [2];
  logic        m_pend[2];
  logic [15:0] m_ctrl;
  logic [31:0] m_cnt;

  aux_pwm_timer dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_be   (bus_be),
    .bus_rdata(bus_rdata),
    .pwm_o    (pwm_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bmerge(input logic [31:0] o, input logic [31:0] n,
                                         input logic [3:0] b);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = b[i] ? n[8*i +: 8] : o[8*i +: 8];
    return r;
  endfunction

  function automatic logic model_pwm();
    logic on;
    on = m_ctrl[9] & m_ctrl[4];
    return on && ((m_cnt < m_act[1]) ^ m_ctrl[10]);
  endfunction

  task automatic model_edge(input logic we, input logic [5:0] a, input logic [31:0] d,
                            input logic [3:0] b);
    logic on, wr_clk;
    logic [31:0] tmp;
    on     = m_ctrl[9] & m_ctrl[4];
    wr_clk = on && (m_cnt >= m_act[0]);
    if (!on || wr_clk) m_cnt = 0;
    else               m_cnt = m_cnt + 1;
    for (int i = 0; i < 2; i++) begin
      if (wr_clk && m_pend[i]) begin
        m_act[i]  = m_sh[i];
        m_pend[i] = 1'b0;
      end
    end
    if (we) begin
      case (a)
        6'h08: m_act[0] = bmerge(m_act[0], d, b);
        6'h0C: m_act[1] = bmerge(m_act[1], d, b);
        6'h10: begin m_sh[0] = bmerge(m_sh[0], d, b); m_pend[0] = 1'b1; end
        6'h14: begin m_sh[1] = bmerge(m_sh[1], d, b); m_pend[1] = 1'b1; end
        6'h28: begin tmp = bmerge({m_ctrl, 16'h0}, d, b); m_ctrl = tmp[31:16]; end
        default: ;
      endcase
    end
  endtask

  // one clock: sample and check output, drive the bus for the coming edge
  task automatic tick(input logic we, input logic [5:0] a, input logic [31:0] d,
                      input logic [3:0] b);
    @(negedge clk);
    last_pwm = pwm_o;
    chk({31'b0, pwm_o}, {31'b0, model_pwm()}, cur_req);
    bus_wr = we; bus_addr = a; bus_wdata = d; bus_be = b;
    model_edge(we, a, d, b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 6'h00, 32'h0, 4'h0);
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    tick(1'b1, a, d, 4'hF);
  endtask

  task automatic ctrl_set(input logic [15:0] v);
    tick(1'b1, 6'h28, {v, 16'h0}, 4'b1100);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a; bus_wdata = 32'h0; bus_be = 4'h0;
    #1;
    chk(bus_rdata, exp, tag);
    model_edge(1'b0, a, 32'h0, 4'h0);
  endtask

  // fixed waveform sequences, oldest sample in the MSB
  task automatic expect_seq(input logic [15:0] bits, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick(1'b0, 6'h00, 32'h0, 4'h0);
      chk({31'b0, last_pwm}, {31'b0, bits[n-1-i]}, tag);
    end
  endtask

  task automatic restart(input logic [31:0] p, input logic [31:0] c, input logic [15:0] cv);
    ctrl_set(16'h0000);
    wr_reg(6'h08, p);
    wr_reg(6'h0C, c);
    ctrl_set(cv);
  endtask

  task automatic t_reset;
    cur_req = "R1";
    rd(6'h08, 32'h0, "R1 active period");
    rd(6'h0C, 32'h0, "R1 active compare");
    rd(6'h10, 32'h0, "R1 shadow period");
    rd(6'h14, 32'h0, "R1 shadow compare");
    rd(6'h28, 32'h0, "R1 control");
    chk({31'b0, pwm_o}, 32'h0, "R1 output low");
  endtask

  task automatic t_regs;
    cur_req = "R2";
    tick(1'b1, 6'h08, 32'h12345678, 4'b0101);
    rd(6'h08, 32'h00340078, "R2 byte lanes");
    tick(1'b1, 6'h28, 32'h00C0_FFFF, 4'b0111);
    rd(6'h28, 32'h00C00000, "R2 control upper half");
    tick(1'b1, 6'h09, 32'hFFFFFFFF, 4'hF);
    rd(6'h08, 32'h00340078, "R2 misaligned write ignored");
    rd(6'h2C, 32'h0, "R2 unmapped read zero");
    ctrl_set(16'h0000);
  endtask

  task automatic t_gate;
    cur_req = "R3";
    wr_reg(6'h08, 32'd3);
    wr_reg(6'h0C, 32'd2);
    ctrl_set(16'h0010);
    expect_seq(16'h0, 4, "R3 count bit only");
    ctrl_set(16'h0200);
    expect_seq(16'h0, 4, "R3 wave bit only");
  endtask

  task automatic t_basic;
    cur_req = "R4";
    restart(32'd3, 32'd1, 16'h0210);
    expect_seq(16'b10001000, 8, "R4 period P=3 C=1");
    cur_req = "R5";
    restart(32'd5, 32'd3, 16'h0210);
    expect_seq(16'b111000111000, 12, "R5 P=5 C=3");
  endtask

  task automatic t_pol;
    cur_req = "R6";
    idle(2);
    ctrl_set(16'h0610);
    idle(10);
    restart(32'd5, 32'd3, 16'h0610);
    expect_seq(16'b000111000111, 12, "R6 inverted P=5 C=3");
  endtask

  task automatic t_corner;
    cur_req = "R7";
    restart(32'd5, 32'd0, 16'h0210);
    expect_seq(16'b000000000000, 12, "R7 compare zero");
    restart(32'd5, 32'd6, 16'h0210);
    expect_seq(16'b111111111111, 12, "R7 compare above period");
    restart(32'd5, 32'd5, 16'h0210);
    expect_seq(16'b111110111110, 12, "R7 compare equals period");
  endtask

  task automatic t_shadow;
    cur_req = "R8";
    restart(32'd5, 32'd2, 16'h0210);
    idle(2);
    wr_reg(6'h10, 32'd2);
    wr_reg(6'h14, 32'd1);
    expect_seq(16'b00100100, 8, "R8 old period completes then new");
    rd(6'h08, 32'd2, "R8 period transferred");
    rd(6'h10, 32'd2, "R2 shadow readback");
    cur_req = "R9";
    wr_reg(6'h0C, 32'd2);
    idle(9);
    rd(6'h0C, 32'd2, "R9 no stale reload");
  endtask

  task automatic t_collide;
    cur_req = "R10";
    while (m_cnt != m_act[0]) idle(1);
    wr_reg(6'h10, 32'd4);
    rd(6'h08, 32'd2, "R10 shadow write on wrap waits");
    idle(8);
    rd(6'h08, 32'd4, "R10 moved at next wrap");
    wr_reg(6'h14, 32'd3);
    while (m_cnt != m_act[0]) idle(1);
    wr_reg(6'h0C, 32'd1);
    rd(6'h0C, 32'd1, "R10 direct write wins");
    idle(12);
    rd(6'h0C, 32'd1, "R10 pending consumed");
  endtask

  task automatic t_disable;
    cur_req = "R11";
    restart(32'd4, 32'd3, 16'h0210);
    idle(1);
    ctrl_set(16'h0000);
    expect_seq(16'b0000, 4, "R11 low after mid-period disable");
    ctrl_set(16'h0210);
    expect_seq(16'b1110011100, 10, "R11 restart from zero");
  endtask

  initial begin
    rst_n = 1'b0;
    bus_wr = 1'b0; bus_addr = 6'h0; bus_wdata = 32'h0; bus_be = 4'h0;
    for (int i = 0; i < 2; i++) begin
      m_act[i] = 0; m_sh[i] = 0; m_pend[i] = 1'b0;
    end
    m_ctrl = 16'h0;
    m_cnt  = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_gate;
    t_basic;
    t_pol;
    t_corner;
    t_shadow;
    t_collide;
    t_disable;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule